// File: doc/BRIEF.md
# Egress Priority Queue Scheduler

This block sits on the egress side of a switch port. Fixed-length cells arrive one word per cycle. The first word of each cell carries a priority tag, and the whole cell is written into the queue for that priority. All queues share one storage array. A scheduler picks which queue sends its oldest cell next. It works in one of two modes, chosen by an input pin: strict priority, or weighted round robin with a 4-bit credit weight for each priority. A per-priority ready mask from the downstream traffic manager removes priorities from the candidate set. The chosen cell leaves as a contiguous burst of words.

Each queue has a high watermark and a low watermark. When a queue fills to the high mark, the block sends a flow-control message that names the port and the priority and sets the stop flag. When a stopped queue drains below the low mark, the block sends a release message. Only one message leaves per cycle, so changes that happen together leave one after another.

Top module: `egress_pq_sched`

## Requirements
- R1: A cell is CELL_WORDS consecutive `in_valid` words. Its priority is the `in_pri` value on its first word. Within one priority, cells leave in arrival order with every word unchanged.
- R2: With `sched_mode` = 0 (strict), each decision picks the lowest-numbered eligible priority. Priority 0 is the most urgent.
- R3: No cell starts for a priority whose `ds_ready` bit was low in the decision cycle, which is the cycle before the cell's first output word.
- R4: If a cell's first word arrives while its queue already holds QDEPTH cells, the whole cell is discarded.
- R5: A cell leaves as CELL_WORDS consecutive cycles with `out_valid` high and `out_pri` constant, with `out_last` high on the final word only. Decisions are made only between cells, and at least one idle cycle separates two cells. After reset, `out_valid` and `fc_valid` are low.
- R6: An empty queue is never selected, whatever its weight or ready bit.
- R7: When a queue reaches HI_MARK cells, one message is sent with `fc_xoff` = 1, `fc_pri` set to that priority and `fc_port` = PORT_ID.
- R8: When a stopped queue falls below LO_MARK cells, one message is sent with `fc_xoff` = 0 for that priority. No message repeats an unchanged state.
- R9: With `sched_mode` = 1 (weighted round robin), the weight of priority p is `weights[4p+3:4p]`. Each cell sent uses one credit. Among eligible queues that still hold credit, the lowest-numbered one is picked. All credits reload from the weights when no eligible queue has credit left.
- R10: In weighted round robin mode, a priority with weight 0 is never selected. In strict mode, the same priority is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Incoming cell word valid |
| in_pri | input | PW | Cell priority, taken from the first word |
| in_data | input | DW | Incoming cell word |
| sched_mode | input | 1 | 0 strict priority, 1 weighted round robin |
| weights | input | 4*NPRI | Per-priority credit weights |
| ds_ready | input | NPRI | Downstream readiness per priority |
| out_valid | output | 1 | Outgoing word valid |
| out_pri | output | PW | Priority of the cell being sent |
| out_data | output | DW | Outgoing cell word |
| out_last | output | 1 | Final word of the cell |
| fc_valid | output | 1 | Flow-control message valid |
| fc_port | output | PORTW | Port identifier carried in the message |
| fc_pri | output | PW | Priority the message refers to |
| fc_xoff | output | 1 | 1 stop, 0 release |

## Verification
Corrupt queue pointers or counts show up at the ports within one cell time. A word then leaves out of order, a dropped cell appears, or a queued cell never leaves. All of these are caught by comparing each outgoing word against its arithmetically encoded priority, sequence number and word index. A wrong credit register changes the weighted order of the next round, so the bench checks the complete order of nine cells against a sequence derived by hand. Errors in the watermark state appear one or two cycles after the count changes, as a missing, extra or misordered message in the flow-control log.

// File: rtl/epq_pkg.sv
package epq_pkg;
  localparam int WEIGHT_W = 4;
  typedef enum logic {
    MODE_STRICT = 1'b0,
    MODE_WRR    = 1'b1
  } sched_mode_e;
endpackage

// File: rtl/epq_store.sv
module epq_store #(
  parameter int NPRI       = 4,
  parameter int DW         = 8,
  parameter int CELL_WORDS = 4,
  parameter int QDEPTH     = 4,
  localparam int PW  = (NPRI > 1) ? $clog2(NPRI) : 1,
  localparam int QAW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int CW  = $clog2(QDEPTH + 1),
  localparam int WIW = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [PW-1:0]      in_pri,
  input  logic [DW-1:0]      in_data,
  input  logic               deq,
  input  logic [PW-1:0]      rd_pri,
  input  logic [WIW-1:0]     rd_word,
  output logic [DW-1:0]      rd_data,
  output logic [NPRI*CW-1:0] cnt_flat
);
  localparam int DEPTH = NPRI * QDEPTH * CELL_WORDS;
  localparam int AW    = $clog2(DEPTH);

  logic [DW-1:0]  mem [DEPTH];
  logic [CW-1:0]  cnt_q  [NPRI];
  logic [CW-1:0]  cnt_d  [NPRI];
  logic [QAW-1:0] wptr_q [NPRI];
  logic [QAW-1:0] wptr_d [NPRI];
  logic [QAW-1:0] rptr_q [NPRI];
  logic [QAW-1:0] rptr_d [NPRI];
  logic [WIW-1:0] widx_q, widx_d;
  logic [PW-1:0]  wpri_q, wpri_d, cur_pri;
  logic           wkeep_q, wkeep_d, cur_keep;
  logic           wr_en, last_in, commit;
  logic [AW-1:0]  wr_addr, rd_addr;

  always_comb begin
    cur_pri  = (widx_q == '0) ? in_pri : wpri_q;
    cur_keep = (widx_q == '0) ? (cnt_q[in_pri] < CW'(QDEPTH)) : wkeep_q;
    last_in  = (widx_q == WIW'(CELL_WORDS - 1));
    wr_en    = in_valid && cur_keep;
    commit   = wr_en && last_in;
    wr_addr  = AW'((int'(cur_pri) * QDEPTH + int'(wptr_q[cur_pri])) * CELL_WORDS
                   + int'(widx_q));
    rd_addr  = AW'((int'(rd_pri) * QDEPTH + int'(rptr_q[rd_pri])) * CELL_WORDS
                   + int'(rd_word));
    rd_data  = mem[rd_addr];
    widx_d   = widx_q;
    wpri_d   = wpri_q;
    wkeep_d  = wkeep_q;
    if (in_valid) begin
      widx_d  = last_in ? '0 : widx_q + 1'b1;
      wpri_d  = cur_pri;
      wkeep_d = cur_keep;
    end
    for (int p = 0; p < NPRI; p++) begin
      cnt_d[p]  = cnt_q[p];
      wptr_d[p] = wptr_q[p];
      rptr_d[p] = rptr_q[p];
      if (commit && cur_pri == PW'(p)) begin
        cnt_d[p]  = cnt_d[p] + 1'b1;
        wptr_d[p] = wptr_q[p] + 1'b1;
      end
      if (deq && rd_pri == PW'(p)) begin
        cnt_d[p]  = cnt_d[p] - 1'b1;
        rptr_d[p] = rptr_q[p] + 1'b1;
      end
      cnt_flat[p*CW +: CW] = cnt_q[p];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx_q  <= '0;
      wpri_q  <= '0;
      wkeep_q <= 1'b0;
      for (int p = 0; p < NPRI; p++) begin
        cnt_q[p]  <= '0;
        wptr_q[p] <= '0;
        rptr_q[p] <= '0;
      end
    end else begin
      widx_q  <= widx_d;
      wpri_q  <= wpri_d;
      wkeep_q <= wkeep_d;
      for (int p = 0; p < NPRI; p++) begin
        cnt_q[p]  <= cnt_d[p];
        wptr_q[p] <= wptr_d[p];
        rptr_q[p] <= rptr_d[p];
      end
    end
  end

  generate
    for (genvar g = 0; g < NPRI; g++) begin : g_chk
      assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q[g] <= CW'(QDEPTH));
    end
  endgenerate

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deq |-> cnt_q[rd_pri] != '0);
endmodule

// File: rtl/epq_pick.sv
module epq_pick
  import epq_pkg::*;
#(
  parameter int NPRI = 4,
  localparam int PW = (NPRI > 1) ? $clog2(NPRI) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic                     mode,
  input  logic [NPRI*WEIGHT_W-1:0] weights,
  input  logic [NPRI-1:0]          elig,
  output logic                     sel_valid,
  output logic [PW-1:0]            sel_pri
);
  logic [WEIGHT_W-1:0] cred_q [NPRI];
  logic [WEIGHT_W-1:0] cred_d [NPRI];
  logic [WEIGHT_W-1:0] eff    [NPRI];
  logic [NPRI-1:0]     holds, cand;
  logic                reload;

  always_comb begin
    for (int p = 0; p < NPRI; p++) holds[p] = elig[p] && (cred_q[p] != '0);
    reload = (mode == MODE_WRR) && (holds == '0) && (elig != '0);
    for (int p = 0; p < NPRI; p++) begin
      eff[p]  = reload ? weights[p*WEIGHT_W +: WEIGHT_W] : cred_q[p];
      cand[p] = elig[p] && ((mode == MODE_STRICT) || (eff[p] != '0));
    end
    sel_valid = (cand != '0);
    sel_pri   = '0;
    for (int p = NPRI - 1; p >= 0; p--) if (cand[p]) sel_pri = PW'(p);
    for (int p = 0; p < NPRI; p++) cred_d[p] = cred_q[p];
    if (go && (mode == MODE_WRR)) begin
      for (int p = 0; p < NPRI; p++) cred_d[p] = eff[p];
      if (sel_valid) cred_d[sel_pri] = eff[sel_pri] - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPRI; p++) cred_q[p] <= '0;
    end else begin
      for (int p = 0; p < NPRI; p++) cred_q[p] <= cred_d[p];
    end
  end

  assert_zero_weight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (go && sel_valid && mode == MODE_WRR) |-> weights[sel_pri*WEIGHT_W +: WEIGHT_W] != '0);
endmodule

// File: rtl/epq_fcgen.sv
module epq_fcgen #(
  parameter int NPRI    = 4,
  parameter int CW      = 3,
  parameter int HI_MARK = 3,
  parameter int LO_MARK = 2,
  parameter int PORTW   = 4,
  parameter int PORT_ID = 5,
  localparam int PW = (NPRI > 1) ? $clog2(NPRI) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPRI*CW-1:0] cnt_flat,
  output logic               fc_valid,
  output logic [PORTW-1:0]   fc_port,
  output logic [PW-1:0]      fc_pri,
  output logic               fc_xoff
);
  logic [NPRI-1:0] xoff_q, xoff_d, sent_q, sent_d, pend;
  logic [CW-1:0]   c;

  always_comb begin
    for (int p = 0; p < NPRI; p++) begin
      c = cnt_flat[p*CW +: CW];
      if (c >= CW'(HI_MARK))     xoff_d[p] = 1'b1;
      else if (c < CW'(LO_MARK)) xoff_d[p] = 1'b0;
      else                       xoff_d[p] = xoff_q[p];
    end
    pend     = xoff_q ^ sent_q;
    fc_valid = (pend != '0);
    fc_pri   = '0;
    for (int p = NPRI - 1; p >= 0; p--) if (pend[p]) fc_pri = PW'(p);
    fc_xoff  = xoff_q[fc_pri];
    fc_port  = PORTW'(PORT_ID);
    sent_d   = sent_q;
    if (fc_valid) sent_d[fc_pri] = xoff_q[fc_pri];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xoff_q <= '0;
      sent_q <= '0;
    end else begin
      xoff_q <= xoff_d;
      sent_q <= sent_d;
    end
  end

  assert_no_repeat_msg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fc_valid |=> !(fc_valid && fc_pri == $past(fc_pri) && fc_xoff == $past(fc_xoff)));
endmodule

// File: rtl/egress_pq_sched.sv
module egress_pq_sched
  import epq_pkg::*;
#(
  parameter int NPRI       = 4,
  parameter int DW         = 8,
  parameter int CELL_WORDS = 4,
  parameter int QDEPTH     = 4,
  parameter int HI_MARK    = 3,
  parameter int LO_MARK    = 2,
  parameter int PORTW      = 4,
  parameter int PORT_ID    = 5,
  localparam int PW  = (NPRI > 1) ? $clog2(NPRI) : 1,
  localparam int CW  = $clog2(QDEPTH + 1),
  localparam int WIW = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [PW-1:0]            in_pri,
  input  logic [DW-1:0]            in_data,
  input  logic                     sched_mode,
  input  logic [NPRI*WEIGHT_W-1:0] weights,
  input  logic [NPRI-1:0]          ds_ready,
  output logic                     out_valid,
  output logic [PW-1:0]            out_pri,
  output logic [DW-1:0]            out_data,
  output logic                     out_last,
  output logic                     fc_valid,
  output logic [PORTW-1:0]         fc_port,
  output logic [PW-1:0]            fc_pri,
  output logic                     fc_xoff
);
  logic [1:0]         rsync_q;
  logic               rst_s;
  logic [NPRI*CW-1:0] cnt_flat;
  logic [NPRI-1:0]    elig;
  logic               go, sel_valid, start;
  logic [PW-1:0]      sel_pri;
  logic               busy_q, busy_d;
  logic [PW-1:0]      cur_q, cur_d;
  logic [WIW-1:0]     word_q, word_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  epq_store #(.NPRI(NPRI), .DW(DW), .CELL_WORDS(CELL_WORDS), .QDEPTH(QDEPTH)) u_store (
    .clk(clk), .rst_n(rst_s), .in_valid(in_valid), .in_pri(in_pri), .in_data(in_data),
    .deq(out_last), .rd_pri(cur_q), .rd_word(word_q), .rd_data(out_data),
    .cnt_flat(cnt_flat));

  epq_pick #(.NPRI(NPRI)) u_pick (
    .clk(clk), .rst_n(rst_s), .go(go), .mode(sched_mode), .weights(weights),
    .elig(elig), .sel_valid(sel_valid), .sel_pri(sel_pri));

  epq_fcgen #(.NPRI(NPRI), .CW(CW), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK),
              .PORTW(PORTW), .PORT_ID(PORT_ID)) u_fc (
    .clk(clk), .rst_n(rst_s), .cnt_flat(cnt_flat), .fc_valid(fc_valid),
    .fc_port(fc_port), .fc_pri(fc_pri), .fc_xoff(fc_xoff));

  always_comb begin
    for (int p = 0; p < NPRI; p++)
      elig[p] = (cnt_flat[p*CW +: CW] != '0) && ds_ready[p];
    go        = !busy_q;
    start     = go && sel_valid;
    out_valid = busy_q;
    out_pri   = cur_q;
    out_last  = busy_q && (word_q == WIW'(CELL_WORDS - 1));
    busy_d    = busy_q;
    cur_d     = cur_q;
    word_d    = word_q;
    if (start) begin
      busy_d = 1'b1;
      cur_d  = sel_pri;
      word_d = '0;
    end else if (busy_q) begin
      word_d = word_q + 1'b1;
      if (out_last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      word_q <= '0;
    end else begin
      busy_q <= busy_d;
      cur_q  <= cur_d;
      word_q <= word_d;
    end
  end

  assert_cell_hold_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && !out_last) |=> (out_valid && $stable(out_pri)));

  assert_gap_after_last_R5: assert property (@(posedge clk) disable iff (!rst_s)
    out_last |=> !out_valid);

  assert_ready_mask_R3: assert property (@(posedge clk) disable iff (!rst_s)
    !out_valid |=> (!out_valid || (($past(ds_ready) >> out_pri) & NPRI'(1)) != '0));
endmodule

// File: tb/test_egress_pq_sched.sv
`timescale 1ns/1ps
module test_egress_pq_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_pri = '0;
  logic [7:0] in_data = '0;
  logic       sched_mode = 1'b0;
  logic [15:0] weights = '0;
  logic [3:0] ds_ready = '0;
  logic       out_valid, out_last, fc_valid, fc_xoff;
  logic [1:0] out_pri, fc_pri;
  logic [7:0] out_data;
  logic [3:0] fc_port;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [1:0] o_pri  [128];
  logic [7:0] o_data [128];
  logic       o_last [128];
  int         n_out = 0;
  logic [1:0] f_pri  [32];
  logic       f_x    [32];
  logic [3:0] f_port [32];
  int         n_fc = 0;

  always #2.5 clk = ~clk;

  egress_pq_sched i_egress_pq_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pri(in_pri), .in_data(in_data),
    .sched_mode(sched_mode), .weights(weights), .ds_ready(ds_ready),
    .out_valid(out_valid), .out_pri(out_pri), .out_data(out_data), .out_last(out_last),
    .fc_valid(fc_valid), .fc_port(fc_port), .fc_pri(fc_pri), .fc_xoff(fc_xoff));

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && n_out < 128) begin
        o_pri[n_out] = out_pri; o_data[n_out] = out_data; o_last[n_out] = out_last;
        n_out++;
      end
      if (fc_valid && n_fc < 32) begin
        f_pri[n_fc] = fc_pri; f_x[n_fc] = fc_xoff; f_port[n_fc] = fc_port;
        n_fc++;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cell(input int p, input int s);
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_pri   = p[1:0];
      in_data  = {p[1:0], s[3:0], w[1:0]};
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_cell(input string req, input int idx, input int p, input int s);
    for (int w = 0; w < 4; w++) begin
      automatic int k = idx * 4 + w;
      automatic logic [7:0] exp = {p[1:0], s[3:0], w[1:0]};
      check(req, $sformatf("cell %0d word %0d data", idx, w), int'(o_data[k]), int'(exp));
      check(req, $sformatf("cell %0d word %0d pri", idx, w), int'(o_pri[k]), p);
      check("R5", $sformatf("cell %0d word %0d last", idx, w), int'(o_last[k]), (w == 3) ? 1 : 0);
    end
  endtask

  task automatic check_fc(input string req, input int idx, input int p, input int x);
    check(req, $sformatf("fc msg %0d pri", idx), int'(f_pri[idx]), p);
    check(req, $sformatf("fc msg %0d flag", idx), int'(f_x[idx]), x);
    check("R7", $sformatf("fc msg %0d port", idx), int'(f_port[idx]), 5);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    // R5 reset state
    check("R5", "out_valid after reset", int'(out_valid), 0);
    check("R7", "fc_valid after reset", int'(fc_valid), 0);

    // Strict order with a readiness mask: one cell each of p3, p1, p0, p2
    sched_mode = 1'b0;
    send_cell(3, 0); send_cell(1, 0); send_cell(0, 0); send_cell(2, 0);
    wait_cyc(4);
    check("R3", "nothing sent while all masked", n_out, 0);
    ds_ready = 4'b1011;
    wait_cyc(40);
    check("R3", "masked p2 held back", n_out, 12);
    check_cell("R2", 0, 0, 0);
    check_cell("R2", 1, 1, 0);
    check_cell("R1", 2, 3, 0);
    ds_ready = 4'b1111;
    wait_cyc(20);
    check("R6", "no extra cells from empty queues", n_out, 16);
    check_cell("R3", 3, 2, 0);
    check("R7", "no message below high mark", n_fc, 0);

    // Overfill p2: fifth cell must be dropped
    ds_ready = 4'b0000;
    for (int s = 0; s < 5; s++) send_cell(2, s);
    wait_cyc(6);
    check("R7", "one stop message", n_fc, 1);
    check_fc("R7", 0, 2, 1);
    ds_ready = 4'b1111;
    wait_cyc(60);
    check("R4", "only QDEPTH cells delivered", n_out, 32);
    for (int s = 0; s < 4; s++) check_cell("R4", 4 + s, 2, s);
    check("R8", "one release message", n_fc, 2);
    check_fc("R8", 1, 2, 0);

    // Weighted round robin: weights p0=2 p1=1 p2=1 p3=0
    ds_ready   = 4'b0000;
    sched_mode = 1'b1;
    weights    = {4'd0, 4'd1, 4'd1, 4'd2};
    for (int s = 0; s < 3; s++) send_cell(0, s);
    for (int s = 0; s < 3; s++) send_cell(1, s);
    for (int s = 0; s < 3; s++) send_cell(2, s);
    send_cell(3, 0);
    wait_cyc(6);
    check("R7", "three stop messages", n_fc, 5);
    check_fc("R7", 2, 0, 1);
    check_fc("R7", 3, 1, 1);
    check_fc("R7", 4, 2, 1);
    ds_ready = 4'b1111;
    wait_cyc(100);
    // rounds: (p0,p0,p1,p2) (p0,p1,p2) then p0 empty (p1,p2)
    begin
      automatic int ord[9] = '{0, 0, 1, 2, 0, 1, 2, 1, 2};
      automatic int seq[4] = '{0, 0, 0, 0};
      for (int i = 0; i < 9; i++) begin
        check_cell("R9", 8 + i, ord[i], seq[ord[i]]);
        seq[ord[i]]++;
      end
    end
    check("R10", "weight 0 priority never sent in WRR", n_out, 68);
    check("R8", "three release messages", n_fc, 8);
    check_fc("R8", 5, 0, 0);
    check_fc("R8", 6, 1, 0);
    check_fc("R8", 7, 2, 0);
    sched_mode = 1'b0;
    wait_cyc(20);
    check("R10", "weight 0 priority sent in strict", n_out, 72);
    check_cell("R10", 17, 3, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule